// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 15-bit logical address into a 16-bit physical address for a memory that is divided into pages and has a single page table. The upper four bits of the request select a page, and the lower eleven bits are carried through as the offset. The page number is compared at the same time against every entry of an eight-entry fully associative translation buffer. On a match, the stored frame number and the offset form the physical address, and the response appears on the next cycle.

When no entry matches, the unit reads the page-table word at base register plus page number through a simple read port with a valid handshake. If the word marks the page as present, the unit writes the (page, frame) pair into the buffer and answers with the translated address. If the page is absent, it answers with a fault flag instead. Only one translation is in flight at a time.

A flush input empties the buffer on a context switch, and a separate load input installs the new table base. Single-cycle hit and miss pulses let an observer measure the hit ratio.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, mem_rd_req, evt_hit and evt_miss are 0. Every buffer entry starts invalid, so the first request always misses.
- R2: A successful response carries rsp_paddr = {frame[4:0], req_laddr[10:0]}. The page number is req_laddr[14:11].
- R3: When a request is accepted (req_valid and req_ready) and its page matches a valid entry, rsp_valid is high on the next cycle with rsp_hit=1 and rsp_fault=0, and no memory read is issued.
- R4: An accepted request that misses raises mem_rd_req on the next cycle, with mem_rd_addr = table base + page number (16-bit sum). Address and request are held until mem_rd_valid is seen, and the response follows one cycle after mem_rd_valid, with rsp_hit=0.
- R5: In a page-table word, bit 5 is the present flag and bits 4:0 are the frame. A present word produces a translated response and refills the buffer, so the next access to that page hits.
- R6: A page-table word with bit 5 clear produces rsp_fault=1 with rsp_paddr=0 and no refill, so the page misses again on its next access.
- R7: A refill goes to the lowest-numbered invalid entry. When all eight entries are valid, the victim is chosen by a round-robin pointer. The pointer starts at entry 0 after reset, advances by one only when an eviction takes place, and is not changed by flush.
- R8: flush invalidates every entry. A request accepted in a cycle with flush high is handled as a miss.
- R9: If flush is high in the same cycle as mem_rd_valid, the refill is dropped and the buffer ends up empty. The response is still returned.
- R10: ptbr_load with ptbr_value replaces the table base. Misses accepted in later cycles fetch from the new base.
- R11: req_ready is low from the acceptance of a missing request until its response cycle. It is low whenever mem_rd_req is high.
- R12: Each accepted request produces exactly one single-cycle pulse, on evt_hit or on evt_miss, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all buffer entries |
| ptbr_load | input | 1 | Load a new page table base |
| ptbr_value | input | 16 | New page table base |
| req_valid | input | 1 | Translation request |
| req_laddr | input | 15 | Logical address |
| req_ready | output | 1 | Unit can accept a request |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 16 | Physical address (0 on fault) |
| rsp_hit | output | 1 | Response came from the buffer |
| rsp_fault | output | 1 | Page not present |
| evt_hit | output | 1 | Hit event pulse |
| evt_miss | output | 1 | Miss event pulse |
| mem_rd_req | output | 1 | Page-table read request |
| mem_rd_addr | output | 16 | Page-table word address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 6 | Page-table word: bit 5 present, bits 4:0 frame |

## Verification
The assertions check the following on every cycle:
- the offset is carried through to the response;
- a hit answers on the next cycle without a memory read;
- a pending read holds its address and is answered one cycle after the read data arrives;
- a fault response reports a zero address;
- the unit is not ready while a fetch is pending;
- each accepted request produces exactly one event pulse;
- a request accepted during a flush is counted as a miss.

Other behaviours can only be shown by the bench's scenarios. These are buffer contents over time: which page hits after a refill, which entry the round-robin pointer evicts, that a flush landing on the refill cycle leaves the buffer empty, that an absent page never gets cached, and that a new table base moves the fetch address.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } xl_state_e;

endpackage

// File: rtl/xlt_victim.sv
module xlt_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               wr_fire,
  output logic [IDX_W-1:0]   wr_idx
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  // lowest-numbered free slot
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign wr_idx = any_free ? free_idx : rr_q;

  // pointer moves only when an occupied slot is overwritten
  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (wr_fire && !any_free) begin
      if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
      else                             rr_q <= rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/xlt_cam.sv
module xlt_cam #(
  parameter int PAGE_W  = 4,
  parameter int FRAME_W = 5,
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               wr_en,
  input  logic [PAGE_W-1:0]  wr_page,
  input  logic [FRAME_W-1:0] wr_frame
);

  logic [ENTRIES-1:0] valid_q;
  logic [PAGE_W-1:0]  key_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   wr_idx;
  logic               wr_fire;

  // flush wins over a refill in the same cycle
  assign wr_fire = wr_en && !flush;

  xlt_victim #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_victim (
    .clk       (clk),
    .rst       (rst),
    .valid_vec (valid_q),
    .wr_fire   (wr_fire),
    .wr_idx    (wr_idx)
  );

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      assign match[g] = valid_q[g] && (key_q[g] == lk_page);

      always_ff @(posedge clk) begin
        if (rst) begin
          valid_q[g] <= 1'b0;
        end else if (flush) begin
          valid_q[g] <= 1'b0;
        end else if (wr_fire && (wr_idx == IDX_W'(g))) begin
          valid_q[g] <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (wr_fire && (wr_idx == IDX_W'(g))) begin
          key_q[g]   <= wr_page;
          frame_q[g] <= wr_frame;
        end
      end
    end
  endgenerate

  assign lk_hit = |match;

  // at most one entry matches, so an OR of the gated frames selects it
  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_frame = lk_frame | frame_q[i];
    end
  end

endmodule

// File: rtl/xlt_ctrl.sv
module xlt_ctrl
  import page_xlate_pkg::*;
#(
  parameter int PAGE_W  = 4,
  parameter int OFS_W   = 11,
  parameter int FRAME_W = 5,
  parameter int ADDR_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic                      ptbr_load,
  input  logic [ADDR_W-1:0]         ptbr_value,
  input  logic                      req_valid,
  input  logic [PAGE_W+OFS_W-1:0]   req_laddr,
  output logic                      req_ready,
  output logic                      rsp_valid,
  output logic [FRAME_W+OFS_W-1:0]  rsp_paddr,
  output logic                      rsp_hit,
  output logic                      rsp_fault,
  output logic                      evt_hit,
  output logic                      evt_miss,
  output logic                      mem_rd_req,
  output logic [ADDR_W-1:0]         mem_rd_addr,
  input  logic                      mem_rd_valid,
  input  logic [FRAME_W:0]          mem_rd_data,
  input  logic                      lk_hit,
  input  logic [FRAME_W-1:0]        lk_frame,
  output logic                      wr_en,
  output logic [PAGE_W-1:0]         wr_page,
  output logic [FRAME_W-1:0]        wr_frame
);

  localparam int LADDR_W = PAGE_W + OFS_W;
  localparam int PADDR_W = FRAME_W + OFS_W;

  xl_state_e         state_q;
  logic [ADDR_W-1:0] ptbr_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;

  logic [PAGE_W-1:0] req_page;
  logic [OFS_W-1:0]  req_ofs;
  logic              accept;
  logic              eff_hit;
  logic              fill;
  logic              present;

  assign req_page = req_laddr[LADDR_W-1:OFS_W];
  assign req_ofs  = req_laddr[OFS_W-1:0];
  assign accept   = req_valid && req_ready;
  assign eff_hit  = lk_hit && !flush;
  assign fill     = (state_q == ST_WALK) && mem_rd_valid;
  assign present  = mem_rd_data[FRAME_W];

  assign wr_en    = fill && present;
  assign wr_page  = page_q;
  assign wr_frame = mem_rd_data[FRAME_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptbr_q <= '0;
    end else if (ptbr_load) begin
      ptbr_q <= ptbr_value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      req_ready   <= 1'b1;
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_hit     <= 1'b0;
      rsp_fault   <= 1'b0;
      evt_hit     <= 1'b0;
      evt_miss    <= 1'b0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      page_q      <= '0;
      ofs_q       <= '0;
    end else begin
      rsp_valid <= 1'b0;
      evt_hit   <= 1'b0;
      evt_miss  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (eff_hit) begin
              rsp_valid <= 1'b1;
              rsp_paddr <= {lk_frame, req_ofs};
              rsp_hit   <= 1'b1;
              rsp_fault <= 1'b0;
              evt_hit   <= 1'b1;
            end else begin
              state_q     <= ST_WALK;
              req_ready   <= 1'b0;
              mem_rd_req  <= 1'b1;
              mem_rd_addr <= ptbr_q + {{(ADDR_W-PAGE_W){1'b0}}, req_page};
              page_q      <= req_page;
              ofs_q       <= req_ofs;
              evt_miss    <= 1'b1;
            end
          end
        end
        ST_WALK: begin
          if (fill) begin
            state_q    <= ST_IDLE;
            req_ready  <= 1'b1;
            mem_rd_req <= 1'b0;
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b0;
            rsp_fault  <= !present;
            rsp_paddr  <= present ? {mem_rd_data[FRAME_W-1:0], ofs_q} : PADDR_W'(0);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
  parameter int PAGE_W  = 4,
  parameter int OFS_W   = 11,
  parameter int FRAME_W = 5,
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic                      ptbr_load,
  input  logic [ADDR_W-1:0]         ptbr_value,
  input  logic                      req_valid,
  input  logic [PAGE_W+OFS_W-1:0]   req_laddr,
  output logic                      req_ready,
  output logic                      rsp_valid,
  output logic [FRAME_W+OFS_W-1:0]  rsp_paddr,
  output logic                      rsp_hit,
  output logic                      rsp_fault,
  output logic                      evt_hit,
  output logic                      evt_miss,
  output logic                      mem_rd_req,
  output logic [ADDR_W-1:0]         mem_rd_addr,
  input  logic                      mem_rd_valid,
  input  logic [FRAME_W:0]          mem_rd_data
);

  localparam int LADDR_W = PAGE_W + OFS_W;
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic               lk_hit;
  logic [FRAME_W-1:0] lk_frame;
  logic               wr_en;
  logic [PAGE_W-1:0]  wr_page;
  logic [FRAME_W-1:0] wr_frame;

  xlt_cam #(
    .PAGE_W  (PAGE_W),
    .FRAME_W (FRAME_W),
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_cam (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .lk_page  (req_laddr[LADDR_W-1:OFS_W]),
    .lk_hit   (lk_hit),
    .lk_frame (lk_frame),
    .wr_en    (wr_en),
    .wr_page  (wr_page),
    .wr_frame (wr_frame)
  );

  xlt_ctrl #(
    .PAGE_W  (PAGE_W),
    .OFS_W   (OFS_W),
    .FRAME_W (FRAME_W),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .ptbr_load    (ptbr_load),
    .ptbr_value   (ptbr_value),
    .req_valid    (req_valid),
    .req_laddr    (req_laddr),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_paddr    (rsp_paddr),
    .rsp_hit      (rsp_hit),
    .rsp_fault    (rsp_fault),
    .evt_hit      (evt_hit),
    .evt_miss     (evt_miss),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .lk_hit       (lk_hit),
    .lk_frame     (lk_frame),
    .wr_en        (wr_en),
    .wr_page      (wr_page),
    .wr_frame     (wr_frame)
  );

endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int PAGE_W  = 4,
  parameter int OFS_W   = 11,
  parameter int FRAME_W = 5,
  parameter int ADDR_W  = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     flush,
  input logic                     req_valid,
  input logic [PAGE_W+OFS_W-1:0]  req_laddr,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic [FRAME_W+OFS_W-1:0] rsp_paddr,
  input logic                     rsp_hit,
  input logic                     rsp_fault,
  input logic                     evt_hit,
  input logic                     evt_miss,
  input logic                     mem_rd_req,
  input logic [ADDR_W-1:0]        mem_rd_addr,
  input logic                     mem_rd_valid
);

  logic [OFS_W-1:0] ofs_cap;

  always_ff @(posedge clk) begin
    if (rst) ofs_cap <= '0;
    else if (req_valid && req_ready) ofs_cap <= req_laddr[OFS_W-1:0];
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (req_ready && !rsp_valid && !mem_rd_req && !evt_hit && !evt_miss));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFS_W-1:0] == ofs_cap));

  a_r3_hit_response: assert property (@(posedge clk) disable iff (rst)
    evt_hit |-> (rsp_valid && rsp_hit && !rsp_fault && !mem_rd_req));

  a_r4_fetch_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  a_r4_rsp_after_fill: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && mem_rd_valid) |=> (rsp_valid && !rsp_hit && !mem_rd_req));

  a_r6_fault_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_hit));

  a_r8_flush_miss: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && flush) |=> evt_miss);

  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !req_ready);

  a_r12_one_event: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> ($countones({evt_hit, evt_miss}) == 1));

  a_r12_event_cause: assert property (@(posedge clk) disable iff (rst)
    (evt_hit || evt_miss) |-> $past(req_valid && req_ready));

endmodule

bind page_xlate_unit page_xlate_chk #(
  .PAGE_W  (PAGE_W),
  .OFS_W   (OFS_W),
  .FRAME_W (FRAME_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .flush        (flush),
  .req_valid    (req_valid),
  .req_laddr    (req_laddr),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_paddr    (rsp_paddr),
  .rsp_hit      (rsp_hit),
  .rsp_fault    (rsp_fault),
  .evt_hit      (evt_hit),
  .evt_miss     (evt_miss),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_valid (mem_rd_valid)
);

// File: tb/page_xlate_unit_tb.sv
`timescale 1ns/1ps
module page_xlate_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        flush;
  logic        flush_dir;
  logic        flush_fill;
  logic        ptbr_load;
  logic [15:0] ptbr_value;
  logic        req_valid;
  logic [14:0] req_laddr;
  logic        req_ready;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic        rsp_hit;
  logic        rsp_fault;
  logic        evt_hit;
  logic        evt_miss;
  logic        mem_rd_req;
  logic [15:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [5:0]  mem_rd_data;

  always #4 clk = ~clk;

  assign flush = flush_dir | flush_fill;

  page_xlate_unit u_dut (
    .clk(clk), .rst(rst), .flush(flush), .ptbr_load(ptbr_load),
    .ptbr_value(ptbr_value), .req_valid(req_valid), .req_laddr(req_laddr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .evt_hit(evt_hit),
    .evt_miss(evt_miss), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  int errors = 0;
  int checks = 0;
  int n_hit = 0, n_miss = 0, e_hit = 0, e_miss = 0;
  bit fill_flush = 1'b0;
  bit last_hit;
  int wait_left = 0;

  // reference buffer state
  bit          m_v  [8];
  logic [3:0]  m_pg [8];
  logic [4:0]  m_fr [8];
  int          m_rr = 0;
  logic [15:0] m_ptbr = 16'h0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // page-table content: bit 5 present, bits 4:0 frame
  function automatic logic [5:0] pte_of(logic [15:0] a);
    logic [4:0] f;
    f = a[9:5] ^ (a[4:0] + 5'd3);
    return {(a[4:0] != 5'h1F), f};
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
  endfunction

  function automatic void model_insert(logic [3:0] pg, logic [4:0] fr);
    int idx;
    idx = -1;
    for (int i = 7; i >= 0; i--) if (!m_v[i]) idx = i;
    if (idx < 0) begin
      idx = m_rr;
      m_rr = (m_rr + 1) % 8;
    end
    m_v[idx] = 1'b1; m_pg[idx] = pg; m_fr[idx] = fr;
  endfunction

  // memory responder with 0..2 cycles of extra latency
  initial begin
    mem_rd_valid = 1'b0; mem_rd_data = '0; flush_fill = 1'b0;
    forever begin
      @(negedge clk);
      mem_rd_valid = 1'b0;
      flush_fill   = 1'b0;
      if (mem_rd_req && !rst) begin
        if (wait_left == 0) begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = pte_of(mem_rd_addr);
          flush_fill   = fill_flush;
          wait_left    = $urandom_range(2, 0);
        end else begin
          wait_left--;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (evt_hit)  n_hit++;
      if (evt_miss) n_miss++;
    end
  end

  task automatic set_base(logic [15:0] v);
    @(negedge clk); ptbr_load = 1'b1; ptbr_value = v;
    @(negedge clk); ptbr_load = 1'b0;
    m_ptbr = v;
  endtask

  task automatic do_flush();
    @(negedge clk); flush_dir = 1'b1;
    @(negedge clk); flush_dir = 1'b0;
    model_clear();
  endtask

  task automatic xlate(logic [14:0] la, bit with_flush, bit at_fill);
    bit          eh;
    logic [4:0]  ef;
    logic [3:0]  pg;
    logic [15:0] ea, exp_pa;
    logic [5:0]  pte;
    bit          exp_fault;
    int          cyc;
    pg = la[14:11];
    eh = 1'b0; ef = '0;
    for (int i = 0; i < 8; i++) if (m_v[i] && m_pg[i] == pg) begin eh = 1'b1; ef = m_fr[i]; end
    if (with_flush) begin eh = 1'b0; model_clear(); end
    ea = m_ptbr + {12'h0, pg};
    pte = pte_of(ea);
    if (eh) begin exp_pa = {ef, la[10:0]}; exp_fault = 1'b0; end
    else begin exp_fault = !pte[5]; exp_pa = pte[5] ? {pte[4:0], la[10:0]} : 16'h0; end
    fill_flush = at_fill;
    @(negedge clk);
    chk("R11 ready before request", req_ready, 1);
    req_valid = 1'b1; req_laddr = la; flush_dir = with_flush;
    @(negedge clk);
    req_valid = 1'b0; flush_dir = 1'b0;
    chk("R12 evt_hit pulse", evt_hit, eh);
    chk("R12 evt_miss pulse", evt_miss, !eh);
    if (eh) begin
      chk("R3 hit response next cycle", rsp_valid, 1);
      chk("R3 no fetch on hit", mem_rd_req, 0);
    end else begin
      chk("R4 fetch request", mem_rd_req, 1);
      chk("R4 R10 fetch address", mem_rd_addr, ea);
      chk("R11 busy during fetch", req_ready, 0);
    end
    cyc = 0;
    while (!rsp_valid && cyc < 40) begin @(negedge clk); cyc++; end
    chk("R4 response arrived", rsp_valid, 1);
    chk("R2 R5 physical address", rsp_paddr, exp_pa);
    chk("R6 fault flag", rsp_fault, exp_fault);
    chk("R3 R5 hit flag", rsp_hit, eh);
    last_hit = rsp_hit;
    fill_flush = 1'b0;
    if (eh) e_hit++; else e_miss++;
    if (!eh && at_fill) model_clear();
    else if (!eh && !exp_fault) model_insert(pg, pte[4:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h2BAD_5EED);
    rst = 1'b1; flush_dir = 1'b0; ptbr_load = 1'b0; ptbr_value = '0;
    req_valid = 1'b0; req_laddr = '0;
    model_clear();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 mem_rd_req", mem_rd_req, 0);
    chk("R1 events", {evt_hit, evt_miss}, 0);

    set_base(16'h0200);
    xlate({4'd3, 11'h123}, 0, 0);
    chk("R1 first access misses", last_hit, 0);
    xlate({4'd3, 11'h7FF}, 0, 0);
    chk("R5 refilled page hits", last_hit, 1);

    // R6: absent page faults and is not cached
    set_base(16'h0210);
    xlate({4'd15, 11'h055}, 0, 0);
    xlate({4'd15, 11'h056}, 0, 0);
    chk("R6 absent page misses again", last_hit, 0);

    // R7: fill all entries, then evict in round-robin order
    set_base(16'h0200);
    do_flush();
    for (int p = 0; p < 8; p++) xlate({4'(p), 11'(p * 9)}, 0, 0);
    xlate({4'd8, 11'h001}, 0, 0);   // evicts entry 0 (page 0)
    xlate({4'd1, 11'h002}, 0, 0);
    chk("R7 page 1 still present", last_hit, 1);
    xlate({4'd0, 11'h003}, 0, 0);   // miss, evicts entry 1 (page 1)
    chk("R7 page 0 was evicted", last_hit, 0);
    xlate({4'd1, 11'h004}, 0, 0);
    chk("R7 page 1 evicted second", last_hit, 0);

    // R8: flush with a request turns a hit into a miss
    xlate({4'd5, 11'h100}, 0, 0);
    xlate({4'd5, 11'h101}, 1, 0);
    chk("R8 flush with request misses", last_hit, 0);
    xlate({4'd6, 11'h102}, 0, 0);
    chk("R8 flush emptied other pages", last_hit, 0);

    // R9: flush on the refill cycle leaves buffer empty
    do_flush();
    xlate({4'd9, 11'h333}, 0, 1);
    xlate({4'd9, 11'h334}, 0, 0);
    chk("R9 refill dropped by flush", last_hit, 0);

    // R10: new base moves the fetch address
    set_base(16'h1234);
    do_flush();
    xlate({4'd2, 11'h010}, 0, 0);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int sel;
      sel = $urandom_range(99, 0);
      if (sel < 4) do_flush();
      else if (sel < 7) set_base(16'($urandom()));
      else xlate({4'($urandom_range(9, 0)), 11'($urandom())},
                 ($urandom_range(29, 0) == 0), ($urandom_range(19, 0) == 0));
    end

    repeat (3) @(negedge clk);
    chk("R12 total hit pulses", n_hit, e_hit);
    chk("R12 total miss pulses", n_miss, e_miss);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule